// File: doc/BRIEF.md
# Triple-Redundant Sequential Truncating Multiplier

This block multiplies two N-bit unsigned operands and returns only the low N bits of the product. It trades area for time: one reduction element processes a slice of the partial-product array on each clock, and the running sum is kept in carry-save form. The low N bits come out after N/ROWS accumulation cycles and one final addition cycle. With the defaults (N = 64, ROWS = 4) the block needs sixteen accumulation cycles and one addition cycle.

The reduction element is built three times. All three copies work on the same slice in the same cycle. A bitwise two-of-three vote over their sum and carry words is the only thing written back to the accumulator, so a corrupted copy never reaches the stored state. A sticky disagreement flag records that the copies differed at some point during the operation. A two-bit injection input lets a testbench invert the whole output of any one copy.

A caller pulses `start` with the operands and then waits for the one-cycle `done` pulse. The result stays on `product` until the next operation completes.

Top module: `tmr_iter_mul`

## Requirements
- R1: When `done` is high, `product` equals (op_a * op_b) mod 2^N, where op_a and op_b are the operand values captured when the operation was accepted.
- R2: `start` is accepted only while the block is idle, and the operands are captured on that accepting clock edge. Operand values driven at any other time have no effect on the result.
- R3: `done` goes high for exactly one cycle, on the (N/ROWS + 1)-th rising edge after the accepting edge.
- R4: A `start` pulse during accumulation or during the final addition cycle is ignored. The running operation keeps its result and its timing.
- R5: While `inj_sel` is 1, 2 or 3, every sum and carry bit from copy 0, 1 or 2 respectively is inverted. With one copy corrupted this way, `product` is still correct.
- R6: `mismatch` goes high after any accumulation cycle in which a copy's output differs from the voted value. Once high, it stays high until the next accepted `start`.
- R7: An accepted `start` clears `mismatch`. A fault-free operation then completes with `mismatch` low.
- R8: After reset, `done`, `mismatch` and `product` are all zero, and the block is idle.
- R9: `product` holds its value from one completion until the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request a new multiplication (ignored when busy) |
| op_a | input | N | Multiplicand |
| op_b | input | N | Multiplier |
| inj_sel | input | 2 | Test hook: 0 none, 1..3 invert copy 0..2 |
| product | output | N | Low N bits of the product |
| done | output | 1 | One-cycle completion pulse |
| mismatch | output | 1 | Sticky copy disagreement flag |

## Verification
The bench uses N = 8 with four rows per cycle, so each operation has two accumulation stages.

It sweeps every multiplicand against a strided set of multipliers that includes both extremes. This covers products that overflow the kept width and operands whose set bits fall in only one stage. Any mistake in row shifting, truncation or carry handling therefore shows up as a wrong low byte.

Some operations are disturbed by a second `start` with different operands while the block is busy. These separate a block that correctly ignores the request from one that restarts or re-samples.

Every multiplicand is then repeated with each copy corrupted in turn, followed by a clean run. These show that the vote masks the fault, that the flag is raised, and that an accepted `start` clears it.

// File: rtl/tmr_mul_pkg.sv
// Shared types for the triple-redundant sequential multiplier.
// Assumes nothing beyond IEEE 1800-2017 packages.
package tmr_mul_pkg;

    // Control phases of one multiplication
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACC  = 2'd1,
        ST_FIN  = 2'd2
    } mul_state_t;

endpackage

// File: rtl/tmr_csa_row.sv
// Word-wide 3:2 carry-save adder, truncated to W bits.
// The carry word is shifted up by one place, and the carry out of the top bit is dropped.
// Assumes modulo-2^W arithmetic is wanted.
module tmr_csa_row #(
    parameter int W = 64
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic [W-1:0] z,
    output logic [W-1:0] s,
    output logic [W-1:0] c
);
    logic [W-1:0] maj;

    // Bitwise sum and majority, carry shifted to next weight
    always_comb begin
        s   = x ^ y ^ z;
        maj = (x & y) | (x & z) | (y & z);
        c   = {maj[W-2:0], 1'b0};
    end
endmodule

// File: rtl/tmr_mul_pe.sv
// One reduction element of the multiplier. It builds ROWS partial-product rows
// from the pre-shifted multiplicand and the low ROWS multiplier bits. A chain of
// 4-2 compressors (two 3:2 rows each) folds those rows into the incoming
// carry-save pair. Assumes ROWS is even and every row is already truncated to N bits.
module tmr_mul_pe #(
    parameter int N    = 64,
    parameter int ROWS = 4
) (
    input  logic [N-1:0]    acc_s,
    input  logic [N-1:0]    acc_c,
    input  logic [N-1:0]    mcand,
    input  logic [ROWS-1:0] mbits,
    output logic [N-1:0]    out_s,
    output logic [N-1:0]    out_c
);
    localparam int LEVELS = ROWS / 2;

    logic [ROWS-1:0][N-1:0]   rows;
    logic [LEVELS:0][N-1:0]   ss;
    logic [LEVELS:0][N-1:0]   cc;
    logic [LEVELS-1:0][N-1:0] ms;
    logic [LEVELS-1:0][N-1:0] mc;

    // Partial-product rows, bits above N-1 discarded by the shift width
    for (genvar j = 0; j < ROWS; j++) begin : g_row
        assign rows[j] = mbits[j] ? (mcand << j) : '0;
    end

    assign ss[0] = acc_s;
    assign cc[0] = acc_c;

    // Chain of 4-2 compressors, each absorbing two rows
    for (genvar p = 0; p < LEVELS; p++) begin : g_cmp
        tmr_csa_row #(.W(N)) u_lo (
            .x(ss[p]), .y(cc[p]), .z(rows[2*p]),
            .s(ms[p]), .c(mc[p])
        );
        tmr_csa_row #(.W(N)) u_hi (
            .x(ms[p]), .y(mc[p]), .z(rows[2*p+1]),
            .s(ss[p+1]), .c(cc[p+1])
        );
    end

    assign out_s = ss[LEVELS];
    assign out_c = cc[LEVELS];
endmodule

// File: rtl/tmr_vote3.sv
// Bitwise two-of-three voter with a disagreement indication.
// Assumes at most one input is faulty for the vote to be correct.
module tmr_vote3 #(
    parameter int W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    output logic [W-1:0] v,
    output logic         differ
);
    // Majority per bit, then flag any input that departs from it
    always_comb begin
        v      = (a & b) | (a & c) | (b & c);
        differ = |((a ^ v) | (b ^ v) | (c ^ v));
    end
endmodule

// File: rtl/tmr_iter_mul.sv
// Sequential truncating multiplier with a triplicated reduction element.
// An accepted start captures the operands. Each accumulation cycle, three copies
// of the element fold ROWS rows into the carry-save accumulator, and only the voted
// words are stored. A final cycle adds sum and carry. Assumes N is a multiple of
// ROWS and ROWS is even.
module tmr_iter_mul #(
    parameter int N    = 64,
    parameter int ROWS = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [N-1:0] op_a,
    input  logic [N-1:0] op_b,
    input  logic [1:0]   inj_sel,
    output logic [N-1:0] product,
    output logic         done,
    output logic         mismatch
);
    import tmr_mul_pkg::*;

    localparam int STAGES = N / ROWS;
    localparam int SW     = (STAGES > 1) ? $clog2(STAGES) : 1;
    localparam logic [SW-1:0] LAST = SW'(STAGES - 1);

    mul_state_t       state;
    logic [SW-1:0]    stage;
    logic [N-1:0]     a_sh;
    logic [N-1:0]     b_sh;
    logic [N-1:0]     acc_s;
    logic [N-1:0]     acc_c;
    logic [2:0][N-1:0] pe_s;
    logic [2:0][N-1:0] pe_c;
    logic [2:0][N-1:0] rep_s;
    logic [2:0][N-1:0] rep_c;
    logic [N-1:0]     vote_s;
    logic [N-1:0]     vote_c;
    logic             diff_s;
    logic             diff_c;
    logic             accept;

    assign accept = (state == ST_IDLE) && start;

    // Three identical copies of the reduction element, each with a test inversion
    for (genvar r = 0; r < 3; r++) begin : g_rep
        tmr_mul_pe #(.N(N), .ROWS(ROWS)) u_pe (
            .acc_s(acc_s), .acc_c(acc_c),
            .mcand(a_sh), .mbits(b_sh[ROWS-1:0]),
            .out_s(pe_s[r]), .out_c(pe_c[r])
        );
        assign rep_s[r] = pe_s[r] ^ {N{inj_sel == 2'(r + 1)}};
        assign rep_c[r] = pe_c[r] ^ {N{inj_sel == 2'(r + 1)}};
    end

    tmr_vote3 #(.W(N)) u_vote_s (
        .a(rep_s[0]), .b(rep_s[1]), .c(rep_s[2]), .v(vote_s), .differ(diff_s)
    );
    tmr_vote3 #(.W(N)) u_vote_c (
        .a(rep_c[0]), .b(rep_c[1]), .c(rep_c[2]), .v(vote_c), .differ(diff_c)
    );

    // Phase sequencing and stage counting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            stage <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    state <= ST_ACC;
                    stage <= '0;
                end
                ST_ACC: begin
                    if (stage == LAST) state <= ST_FIN;
                    else               stage <= stage + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Operand shifting and voted carry-save accumulation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_sh  <= '0;
            b_sh  <= '0;
            acc_s <= '0;
            acc_c <= '0;
        end else if (accept) begin
            a_sh  <= op_a;
            b_sh  <= op_b;
            acc_s <= '0;
            acc_c <= '0;
        end else if (state == ST_ACC) begin
            a_sh  <= a_sh << ROWS;
            b_sh  <= b_sh >> ROWS;
            acc_s <= vote_s;
            acc_c <= vote_c;
        end
    end

    // Final addition, completion pulse and sticky disagreement flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            product  <= '0;
            done     <= 1'b0;
            mismatch <= 1'b0;
        end else begin
            done <= (state == ST_FIN);
            if (state == ST_FIN) product <= acc_s + acc_c;
            if (accept)
                mismatch <= 1'b0;
            else if (state == ST_ACC && (diff_s || diff_c))
                mismatch <= 1'b1;
        end
    end
endmodule

// File: rtl/tmr_iter_mul_chk.sv
// Protocol checks for tmr_iter_mul, attached by bind.
// Assumes the internal phase register is named state.
module tmr_iter_mul_chk (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   start,
    input logic                   done,
    input logic                   mismatch,
    input logic [1:0]             inj_sel,
    input tmr_mul_pkg::mul_state_t state
);
    import tmr_mul_pkg::*;

    // R3
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3
    done_after_fin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(state) == ST_FIN);

    // R7
    clear_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start) |=> (!mismatch && state == ST_ACC));

    // R6
    flag_on_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACC && inj_sel != 2'd0) |=> mismatch);

    // R6
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mismatch && !(state == ST_IDLE && start)) |=> mismatch);

    // R4
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACC && start) |=> state != ST_IDLE);
endmodule

bind tmr_iter_mul tmr_iter_mul_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done),
    .mismatch(mismatch), .inj_sel(inj_sel), .state(state)
);

// File: tb/test_tmr_iter_mul.sv
// Self-checking bench: N = 8, four rows per cycle, strided exhaustive sweep.
module test_tmr_iter_mul;
    localparam int N      = 8;
    localparam int ROWS   = 4;
    localparam int STAGES = N / ROWS;
    localparam int LAT    = STAGES + 2;   // negedges from start drive to done seen

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [N-1:0] op_a = '0;
    logic [N-1:0] op_b = '0;
    logic [1:0]   inj_sel = 2'd0;
    logic [N-1:0] product;
    logic         done;
    logic         mismatch;

    int nchk = 0;
    int nfail = 0;
    int cycles = 0;

    always #4 clk = ~clk;   // 125 MHz

    tmr_iter_mul #(.N(N), .ROWS(ROWS)) i_tmr_iter_mul (
        .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
        .inj_sel(inj_sel), .product(product), .done(done), .mismatch(mismatch)
    );

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Watchdog: an expired run counts as a failure
    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            nfail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
            summary();
            $finish;
        end
    end

    // One operation; optional disturbing start while busy, optional replica fault
    task automatic run_op(input int a, input int b, input logic [1:0] sel, input bit disturb);
        int k;
        int exp;
        logic [N-1:0] held;
        exp = (a * b) & ((1 << N) - 1);
        @(negedge clk);
        op_a = N'(a); op_b = N'(b); inj_sel = sel; start = 1'b1;
        @(negedge clk);
        start = 1'b0; op_a = ~N'(a); op_b = ~N'(b);   // R2: later values must not matter
        k = 1;
        while (!done && k < 20) begin
            @(negedge clk);
            k++;
            if (disturb && !done && k >= 2) begin   // R4: request while busy
                start = 1'b1; op_a = N'(b); op_b = N'(a + 1);
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        check(k == LAT, "R3 latency", k, LAT);
        check(product == N'(exp), (sel != 0) ? "R5 masked fault product" :
              (disturb ? "R4 busy start ignored" : "R1 product"), int'(product), exp);
        check(mismatch == (sel != 2'd0), "R6 mismatch flag", int'(mismatch), int'(sel != 2'd0));
        held = product;
        @(negedge clk);
        inj_sel = 2'd0;
        check(done == 1'b0, "R3 single-cycle done", int'(done), 0);
        check(product == held, "R9 product held", int'(product), int'(held));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R8 reset state
        check(done == 1'b0, "R8 done at reset", int'(done), 0);
        check(mismatch == 1'b0, "R8 mismatch at reset", int'(mismatch), 0);
        check(product == '0, "R8 product at reset", int'(product), 0);
        rst_n = 1'b1;

        // R1 / R4 sweep
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b += 5) begin
                run_op(a, b, 2'd0, ((a + b) % 7) == 0);
            end
            run_op(a, 255, 2'd0, 1'b0);
        end

        // R5 / R6 each replica corrupted, then R7 clean run clears the flag
        for (int s = 1; s < 4; s++) begin
            for (int a = 0; a < 256; a++) begin
                run_op(a, a ^ 8'h5A, 2'(s), 1'b0);
            end
            run_op(37, 201, 2'd0, 1'b0);
            check(mismatch == 1'b0, "R7 flag cleared by start", int'(mismatch), 0);
        end

        summary();
        $finish;
    end
endmodule